// File: doc/BRIEF.md
# Carrier Resonance Search Controller

This controller finds the oscillator setting at which an on-off-keyed transmitter drives a large-area interconnect hardest. Because the line's impedance is not known beforehand, the carrier is tuned once, before data transfer begins, by stepping a digitally controlled oscillator through its whole code range. For each code, the local receiver listens to its own transmission, and the received amplitude is digitized by a dual-slope converter. The converter integrates for a fixed time and then counts the de-integration time until an external comparator trips.

The controller sequences the converter's integrate and de-integrate enables and counts the de-integrate time itself. It keeps the code that produced the largest count. When the sweep ends, it parks the oscillator on that code and raises a lock flag. A new start request discards all previous results and sweeps again from the lowest code. The oscillator, the receiver front end, the analog integrator and the comparator are all outside this block.

Top module: `carrier_cal_ctrl`

## Requirements
- R1: After reset, `locked_o`, `int_en_o` and `deint_en_o` are 0 and `dco_code_o` is 0. They stay that way until `start_i` is seen high.
- R2: Each conversion holds `int_en_o` high for exactly `INT_CYCLES` consecutive cycles. `deint_en_o` rises on the cycle right after that and is never high together with `int_en_o`.
- R3: The de-integrate cycles are numbered from 0. If `cmp_i` is first sampled high in cycle k (with k at or below the saturation value), `deint_en_o` lasts k+1 cycles and the stored count is k.
- R4: The count saturates at 2^`CNT_W`-1. If `cmp_i` never trips, `deint_en_o` lasts 2^`CNT_W` cycles and the count equals the saturation value.
- R5: One sweep performs exactly one conversion per code. The codes run in ascending order from 0 to 2^`CODE_W`-1, and `dco_code_o` equals the code under test while its conversion runs.
- R6: The kept code changes only when a new count is strictly greater than the stored maximum, which starts at 0. On a tie the lower code is kept, and if every count is 0 the result is code 0.
- R7: After the last code's conversion, `locked_o` goes high and `dco_code_o` shows the kept code. Both hold, with no converter activity, until `start_i` is raised again.
- R8: A cycle with `start_i` high, in any state, does four things on the next cycle: it abandons any conversion in progress, clears the stored maximum, drops `locked_o` and sets `dco_code_o` to 0. A new sweep then begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or restart the calibration sweep |
| cmp_i | input | 1 | Comparator output, high once the integrator has discharged |
| dco_code_o | output | CODE_W | Oscillator code: the code under test during the sweep, the kept code once locked |
| int_en_o | output | 1 | Integrate-phase enable for the converter |
| deint_en_o | output | 1 | De-integrate-phase enable for the converter |
| locked_o | output | 1 | Calibration finished; `dco_code_o` is final |

## Verification
The bench models the comparator from a per-code trip time, then sweeps a reduced configuration under several amplitude profiles. The profiles cover a unique peak, a three-way tie, several codes at saturation, all-zero amplitude, and a peak on the last code.

- A design that updates on greater-or-equal would lock onto the highest of the tied codes instead of the lowest.
- A design with an off-by-one in the de-integrate counter would make the phase one cycle too long or too short, and the bench checks that length on every conversion.
- A design that forgot to clear the maximum on restart would cling to an earlier, larger peak when a weaker profile follows.
- A design that ignored a mid-sweep restart would finish with a short or mixed sweep.

// File: rtl/carrier_cal_pkg.sv
package carrier_cal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_RUN,
        CAL_LOCK
    } cal_state_e;

    typedef enum logic [1:0] {
        ADC_IDLE,
        ADC_INT,
        ADC_DEINT
    } adc_state_e;

endpackage

// File: rtl/ds_adc_seq.sv
module ds_adc_seq
    import carrier_cal_pkg::*;
#(
    parameter int INT_CYCLES = 256,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             go_i,
    input  logic             cmp_i,
    output logic             int_en_o,
    output logic             deint_en_o,
    output logic             done_o,
    output logic [CNT_W-1:0] result_o
);

    localparam int TMR_W = $clog2(INT_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        adc_state_e       state;
        logic [TMR_W-1:0] timer;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CNT_W-1:0] result;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (clear_i) begin
            seq_d.state = ADC_IDLE;
            seq_d.timer = '0;
            seq_d.cnt   = '0;
        end else begin
            case (seq_q.state)
                ADC_IDLE: begin
                    if (go_i) begin
                        seq_d.state = ADC_INT;
                        seq_d.timer = '0;
                    end
                end
                ADC_INT: begin
                    if (seq_q.timer == TMR_LAST) begin
                        seq_d.state = ADC_DEINT;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.timer = seq_q.timer + 1'b1;
                    end
                end
                ADC_DEINT: begin
                    if (cmp_i || seq_q.cnt == CNT_MAX) begin
                        seq_d.state  = ADC_IDLE;
                        seq_d.done   = 1'b1;
                        seq_d.result = seq_q.cnt;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                default: seq_d.state = ADC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ADC_IDLE, timer: '0, cnt: '0, done: 1'b0, result: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign int_en_o   = (seq_q.state == ADC_INT);
    assign deint_en_o = (seq_q.state == ADC_DEINT);
    assign done_o     = seq_q.done;
    assign result_o   = seq_q.result;

    // R2: the integrate phase hands over straight to de-integration
    assert_int_handover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en_o && seq_q.timer == TMR_LAST && !clear_i) |=> (deint_en_o && !int_en_o))
        else $error("integrate phase did not hand over to de-integration");

    // R3: a tripped comparator ends de-integration on the next edge with a result
    assert_deint_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (deint_en_o && cmp_i && !clear_i) |=> (!deint_en_o && done_o && result_o == $past(seq_q.cnt)))
        else $error("de-integration did not stop on comparator trip");

    // R4: the counter saturates rather than wrapping
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (deint_en_o && seq_q.cnt == CNT_MAX && !clear_i) |=> (!deint_en_o && done_o && result_o == CNT_MAX))
        else $error("de-integrate counter passed saturation");

endmodule

// File: rtl/peak_keeper.sv
module peak_keeper #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  val_i,
    output logic [CODE_W-1:0] best_code_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  val;
    } peak_t;

    peak_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clear_i) begin
            pk_d.code = '0;
            pk_d.val  = '0;
        end else if (upd_i && val_i > pk_q.val) begin
            pk_d.code = code_i;
            pk_d.val  = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '{code: '0, val: '0};
        end else begin
            pk_q <= pk_d;
        end
    end

    assign best_code_o = pk_q.code;

    // R6: the stored maximum never falls between restarts
    assert_max_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> pk_q.val >= $past(pk_q.val))
        else $error("stored maximum decreased");

    // R6: a count that does not beat the maximum leaves the kept code alone
    assert_tie_keeps_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !clear_i && val_i <= pk_q.val) |=> $stable(pk_q.code))
        else $error("kept code changed without a strictly larger count");

endmodule

// File: rtl/carrier_cal_ctrl.sv
module carrier_cal_ctrl
    import carrier_cal_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int INT_CYCLES = 256,
    parameter int CNT_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] dco_code_o,
    output logic              int_en_o,
    output logic              deint_en_o,
    output logic              locked_o
);

    localparam logic [CODE_W-1:0] CODE_LAST = {CODE_W{1'b1}};

    typedef struct packed {
        cal_state_e        state;
        logic [CODE_W-1:0] code;
        logic              go;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              adc_done;
    logic [CNT_W-1:0]  adc_result;
    logic [CODE_W-1:0] best_code;
    logic              meas_upd;

    ds_adc_seq #(
        .INT_CYCLES (INT_CYCLES),
        .CNT_W      (CNT_W)
    ) i_adc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .go_i       (ctl_q.go),
        .cmp_i      (cmp_i),
        .int_en_o   (int_en_o),
        .deint_en_o (deint_en_o),
        .done_o     (adc_done),
        .result_o   (adc_result)
    );

    assign meas_upd = adc_done && (ctl_q.state == CAL_RUN);

    peak_keeper #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) i_peak (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .upd_i       (meas_upd),
        .code_i      (ctl_q.code),
        .val_i       (adc_result),
        .best_code_o (best_code)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.go = 1'b0;
        if (start_i) begin
            ctl_d.state = CAL_RUN;
            ctl_d.code  = '0;
            ctl_d.go    = 1'b1;
        end else if (meas_upd) begin
            if (ctl_q.code == CODE_LAST) begin
                ctl_d.state = CAL_LOCK;
            end else begin
                ctl_d.code = ctl_q.code + 1'b1;
                ctl_d.go   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: CAL_IDLE, code: '0, go: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign locked_o   = (ctl_q.state == CAL_LOCK);
    assign dco_code_o = locked_o ? best_code : ctl_q.code;

    // R5: each finished conversion advances the sweep by exactly one code
    assert_sweep_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_upd && !start_i && ctl_q.code != CODE_LAST) |=> (dco_code_o == $past(ctl_q.code) + 1'b1 && !locked_o))
        else $error("sweep did not step to the next code");

    // R7: lock holds steady with no converter activity
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !start_i) |=> (locked_o && $stable(dco_code_o) && !int_en_o && !deint_en_o))
        else $error("locked output moved without a restart");

    // R8: restart abandons everything and returns to code 0
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!locked_o && dco_code_o == '0 && !int_en_o && !deint_en_o))
        else $error("restart did not clear the sweep");

endmodule

// File: tb/test_carrier_cal_ctrl.sv
`timescale 1ns/1ps
module test_carrier_cal_ctrl;

    localparam int CW    = 3;
    localparam int IC    = 8;
    localparam int NW    = 5;
    localparam int NCODE = 1 << CW;
    localparam int MAXV  = (1 << NW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cmp_i = 1'b0;
    logic [CW-1:0] dco_code_o;
    logic          int_en_o;
    logic          deint_en_o;
    logic          locked_o;

    carrier_cal_ctrl #(
        .CODE_W     (CW),
        .INT_CYCLES (IC),
        .CNT_W      (NW)
    ) i_carrier_cal_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .dco_code_o (dco_code_o),
        .int_en_o   (int_en_o),
        .deint_en_o (deint_en_o),
        .locked_o   (locked_o)
    );

    always #2.5 clk = ~clk;

    int  prof [NCODE];
    int  nchk = 0;
    int  nfail = 0;
    int  meas_cnt = 0;
    int  int_len = 0;
    int  deint_len = 0;
    int  cur_code = 0;
    bit  prev_int = 1'b0;
    bit  prev_deint = 1'b0;
    bit  mon_on = 1'b0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic int expect_code();
        int best = 0;
        int bval = 0;
        for (int c = 0; c < NCODE; c++) begin
            if (sat(prof[c]) > bval) begin
                bval = sat(prof[c]);
                best = c;
            end
        end
        return best;
    endfunction

    // comparator model and phase monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_on || start_i) begin
                int_len = 0; deint_len = 0; meas_cnt = 0;
                prev_int = 1'b0; prev_deint = 1'b0; cmp_i = 1'b0;
            end else begin
                if (int_en_o && !prev_int) begin
                    chk(dco_code_o == CW'(meas_cnt), "R5 code order", int'(dco_code_o), meas_cnt);
                    cur_code = int'(dco_code_o);
                    meas_cnt++;
                end
                if (int_en_o) int_len++;
                if (prev_int && !int_en_o) begin
                    chk(int_len == IC, "R2 integrate length", int_len, IC);
                    chk(deint_en_o, "R2 de-integrate follows", int'(deint_en_o), 1);
                    int_len = 0;
                end
                chk(!(int_en_o && deint_en_o), "R2 phase overlap", int'(int_en_o && deint_en_o), 0);
                if (deint_en_o) begin
                    cmp_i = (deint_len >= prof[cur_code]);
                    deint_len++;
                end else begin
                    cmp_i = 1'b0;
                end
                if (prev_deint && !deint_en_o) begin
                    chk(deint_len == sat(prof[cur_code]) + 1,
                        (prof[cur_code] > MAXV) ? "R4 saturated length" : "R3 de-integrate length",
                        deint_len, sat(prof[cur_code]) + 1);
                    deint_len = 0;
                end
                prev_int   = int_en_o;
                prev_deint = deint_en_o;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        chk(!locked_o && dco_code_o == '0 && !int_en_o && !deint_en_o,
            "R8 restart clears", int'(locked_o), 0);
    endtask

    task automatic wait_lock(input string req);
        int n = 0;
        while (!locked_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(locked_o, "R7 lock reached", int'(locked_o), 1);
        chk(meas_cnt == NCODE, "R5 one conversion per code", meas_cnt, NCODE);
        chk(int'(dco_code_o) == expect_code(), req, int'(dco_code_o), expect_code());
    endtask

    task automatic hold_check(input int cycles);
        int exp = int'(dco_code_o);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(locked_o && int'(dco_code_o) == exp && !int_en_o && !deint_en_o,
                "R7 lock holds", int'(dco_code_o), exp);
        end
    endtask

    // watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCODE; c++) prof[c] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state and idle until start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!locked_o && !int_en_o && !deint_en_o && dco_code_o == '0,
                "R1 idle after reset", int'(int_en_o || deint_en_o || locked_o), 0);
        end
        mon_on = 1'b1;

        prof = '{3, 7, 12, 20, 25, 29, 14, 4};
        pulse_start();
        wait_lock("R6 unique peak");
        hold_check(30);

        // R8: weaker profile after lock must not keep the old maximum
        prof = '{1, 3, 9, 2, 2, 1, 0, 0};
        pulse_start();
        wait_lock("R8 maximum cleared on restart");

        prof = '{2, 9, 17, 17, 6, 17, 1, 0};
        pulse_start();
        wait_lock("R6 tie keeps lowest code");

        prof = '{10, 40, 33, 31, 50, 5, 2, 1};
        pulse_start();
        wait_lock("R4 saturated counts tie");

        prof = '{0, 0, 0, 0, 0, 0, 0, 0};
        pulse_start();
        wait_lock("R6 all-zero gives code 0");

        prof = '{1, 2, 3, 4, 5, 6, 7, 30};
        pulse_start();
        wait_lock("R7 peak on last code");
        hold_check(10);

        // R8: restart in the middle of a sweep
        prof = '{3, 7, 12, 20, 25, 29, 14, 4};
        pulse_start();
        repeat (100) @(negedge clk);
        chk(!locked_o, "R8 mid-sweep not yet locked", int'(locked_o), 0);
        prof = '{5, 1, 1, 1, 1, 1, 30, 2};
        pulse_start();
        wait_lock("R8 mid-sweep restart result");

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule